// File: doc/BRIEF.md
# DMA Request Burst Handshake Controller

This block sits between a device's main endpoint buffer and an external DMA engine. Software programs an 8-bit setup register with a start bit, a transfer direction, an auto-restart bit and a 2-bit burst-size field. Once the buffer is ready, the block raises a request toward the DMA engine. It counts the acknowledged transfers, drops the request at the end of each burst and raises it again for the next burst. It stops when the engine signals end of transfer, or when software clears the start bit.

Each endpoint packet carries a two-byte header: a status byte at buffer offset 0 and a length byte at offset 1. The DMA stream carries payload only. On a read (buffer to external memory), the block pops and discards the two header bytes before the first request. On a write (external memory to buffer), it places payload from offset 2 onward. When the packet ends, it writes the status byte and then the length byte, which holds the number of payload bytes accepted. The block drives only buffer strobes, an address and a write-source select. The data path stays outside.

Top module: `dmac_burst_ctrl`

## Requirements
- R1: After reset the setup register reads 0x40, and `dma_req`, `buf_rd_stb` and `buf_wr_stb` are low.
- R2: Setup bits are: [1:0] burst code, [2] start, [3] direction (1 = write into buffer, 0 = read from buffer), [4] auto-restart, [7:5] stored only. With start set, a new packet begins only when `buf_full` is high (read) or `buf_empty` is high (write). No request is raised otherwise.
- R3: A read packet begins with two header pops (`buf_rd_stb` at address 0, then at address 1) with `dma_req` low. `dma_req` rises in the cycle after them. Payload transfer k pops address 2+k.
- R4: With burst code 00, the request drops after any cycle in which `dmack_n` is low while it is raised. It rises again after one low cycle.
- R5: Burst codes 01, 10 and 11 hold the request for 4, 8 and 16 counted transfers. The request then drops for exactly one cycle and rises again.
- R6: A transfer counts only when `dmack_n` is low together with `rd_n` (read) or `wr_n` (write). Each counted transfer gives one strobe in the cycle after it. The opposite strobe is ignored.
- R7: `eot_n` low together with `dmack_n` low and either `rd_n` or `wr_n` low, while requesting, ends the packet. Without auto-restart it also clears the start bit. `eot_n` without `dmack_n` has no effect.
- R8: A setup write with the start bit at 0 lowers `dma_req` two cycles after the write cycle. No further request follows.
- R9: With auto-restart set, an end of transfer leaves the start bit set. A new packet, including the header pops on a read, begins as soon as the buffer condition holds.
- R10: When a write packet ends, the block writes the status byte (`buf_wr_sel` = 01, address 0). In the next cycle it writes the length byte (`buf_wr_sel` = 10, address 1, `hdr_len` = payload count). Payload writes use `buf_wr_sel` = 00.
- R11: After PAYLOAD_MAX payload transfers, the packet ends without clearing the start bit. This takes priority over a burst boundary. A write writes its header with length PAYLOAD_MAX. The next packet starts when the buffer condition holds again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Setup register write strobe |
| cfg_wdata | input | 8 | Setup register write value |
| cfg_rdata | output | 8 | Setup register contents |
| buf_full | input | 1 | Main endpoint buffer holds a packet |
| buf_empty | input | 1 | Main endpoint buffer is empty |
| dmack_n | input | 1 | DMA acknowledge, active low |
| eot_n | input | 1 | End of transfer, active low |
| rd_n | input | 1 | Read strobe from DMA engine, active low |
| wr_n | input | 1 | Write strobe from DMA engine, active low |
| dma_req | output | 1 | DMA request |
| buf_rd_stb | output | 1 | Pop one byte from the buffer |
| buf_wr_stb | output | 1 | Write one byte into the buffer |
| buf_addr | output | ADDR_W | Buffer byte offset for the strobe |
| buf_wr_sel | output | 2 | Write source: 00 payload, 01 status, 10 length |
| hdr_len | output | 8 | Length byte value for the header write |

## Verification
The main function is driven with every burst code in both directions. Each packet is one transfer longer than two bursts, so the drop-and-rise rhythm, the payload addressing and the final partial burst all appear.

Handshakes with the wrong strobe show that counting depends on the direction qualifier. An end-of-transfer without acknowledge tells termination apart from the raw `eot_n` level.

A packet that runs to the buffer capacity on a burst boundary shows that the capacity end takes priority over the gap. The auto-restart run shows that the header pops repeat on restart. The software-stop and buffer-not-ready cases check that a raised start bit alone never produces a request.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SKIP0,
    ST_SKIP1,
    ST_REQ,
    ST_GAP,
    ST_HDR_ST,
    ST_HDR_LEN
  } dmac_state_e;

  typedef struct packed {
    logic [2:0] spare;
    logic       reload;
    logic       dir;
    logic       en;
    logic [1:0] burst;
  } dmac_cfg_t;

  localparam logic [7:0] CFG_RESET   = 8'h40;
  localparam int         BEAT_W      = 5;

  localparam logic [1:0] SEL_PAYLOAD = 2'd0;
  localparam logic [1:0] SEL_STATUS  = 2'd1;
  localparam logic [1:0] SEL_LEN     = 2'd2;

  function automatic logic [BEAT_W-1:0] burst_len(input logic [1:0] code);
    case (code)
      2'd0:    burst_len = BEAT_W'(1);
      2'd1:    burst_len = BEAT_W'(4);
      2'd2:    burst_len = BEAT_W'(8);
      default: burst_len = BEAT_W'(16);
    endcase
  endfunction

endpackage

// File: rtl/dmac_cnt.sv
module dmac_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + W'(1);
  end

endmodule

// File: rtl/dmac_cfg_reg.sv
module dmac_cfg_reg
  import dmac_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  logic [7:0] wdata,
  input  logic      eot_clr,
  output dmac_cfg_t cfg
);

  // a software write wins over a same-cycle end-of-transfer clear
  always_ff @(posedge clk) begin
    if (rst)          cfg <= dmac_cfg_t'(CFG_RESET);
    else if (wr_en)   cfg <= dmac_cfg_t'(wdata);
    else if (eot_clr) cfg.en <= 1'b0;
  end

endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
#(
  parameter int PAYLOAD_MAX = 64,
  parameter int CNT_W       = 7,
  parameter int ADDR_W      = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_dir,
  input  logic              cfg_reload,
  input  logic [1:0]        cfg_burst,
  input  logic              buf_full,
  input  logic              buf_empty,
  input  logic              dmack_n,
  input  logic              eot_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [CNT_W-1:0]  pay_cnt,
  input  logic [BEAT_W-1:0] beat_cnt,
  output logic              pay_clr,
  output logic              pay_inc,
  output logic              beat_clr,
  output logic              beat_inc,
  output logic              eot_clr,
  output logic              dma_req,
  output logic              buf_rd_stb,
  output logic              buf_wr_stb,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [1:0]        buf_wr_sel,
  output logic [7:0]        hdr_len
);

  dmac_state_e state, state_d;

  logic in_req, ack, xfer, xfer_ok, eot_hit, cap_hit, beat_done, pkt_end;

  assign in_req    = (state == ST_REQ);
  assign ack       = in_req && !dmack_n;
  assign xfer      = ack && (cfg_dir ? !wr_n : !rd_n);
  assign xfer_ok   = xfer && cfg_en;
  assign eot_hit   = ack && !eot_n && (!rd_n || !wr_n);
  assign cap_hit   = xfer && ((pay_cnt + CNT_W'(1)) == CNT_W'(PAYLOAD_MAX));
  assign beat_done = (cfg_burst == 2'd0) ? ack
                   : (xfer && ((beat_cnt + BEAT_W'(1)) == burst_len(cfg_burst)));
  assign pkt_end   = eot_hit || cap_hit;

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE: begin
        if (cfg_en) begin
          if (!cfg_dir && buf_full)      state_d = ST_SKIP0;
          else if (cfg_dir && buf_empty) state_d = ST_REQ;
        end
      end
      ST_SKIP0:   state_d = cfg_en ? ST_SKIP1 : ST_IDLE;
      ST_SKIP1:   state_d = cfg_en ? ST_REQ   : ST_IDLE;
      ST_REQ: begin
        if (!cfg_en)        state_d = ST_IDLE;
        else if (pkt_end)   state_d = cfg_dir ? ST_HDR_ST : ST_IDLE;
        else if (beat_done) state_d = ST_GAP;
      end
      ST_GAP:     state_d = cfg_en ? ST_REQ : ST_IDLE;
      ST_HDR_ST:  state_d = ST_HDR_LEN;
      ST_HDR_LEN: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign pay_clr  = (state == ST_IDLE);
  assign pay_inc  = xfer_ok;
  assign beat_clr = !in_req;
  assign beat_inc = xfer_ok;
  assign eot_clr  = eot_hit && cfg_en && !cfg_reload;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_d;
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      dma_req    <= 1'b0;
      buf_rd_stb <= 1'b0;
      buf_wr_stb <= 1'b0;
      buf_addr   <= '0;
      buf_wr_sel <= SEL_PAYLOAD;
      hdr_len    <= '0;
    end else begin
      dma_req    <= (state_d == ST_REQ);
      buf_rd_stb <= (state_d == ST_SKIP0) || (state_d == ST_SKIP1) ||
                    (xfer_ok && !cfg_dir);
      buf_wr_stb <= (state == ST_HDR_ST) || (state == ST_HDR_LEN) ||
                    (xfer_ok && cfg_dir);
      if ((state_d == ST_SKIP0) || (state == ST_HDR_ST))
        buf_addr <= ADDR_W'(0);
      else if ((state_d == ST_SKIP1) || (state == ST_HDR_LEN))
        buf_addr <= ADDR_W'(1);
      else
        buf_addr <= ADDR_W'(pay_cnt) + ADDR_W'(2);
      if (state == ST_HDR_ST)       buf_wr_sel <= SEL_STATUS;
      else if (state == ST_HDR_LEN) buf_wr_sel <= SEL_LEN;
      else                          buf_wr_sel <= SEL_PAYLOAD;
      if (state == ST_HDR_LEN) hdr_len <= 8'(pay_cnt);
    end
  end

endmodule

// File: rtl/dmac_burst_ctrl.sv
module dmac_burst_ctrl
  import dmac_pkg::*;
#(
  parameter  int PAYLOAD_MAX = 64,
  localparam int ADDR_W      = $clog2(PAYLOAD_MAX + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              buf_full,
  input  logic              buf_empty,
  input  logic              dmack_n,
  input  logic              eot_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              dma_req,
  output logic              buf_rd_stb,
  output logic              buf_wr_stb,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [1:0]        buf_wr_sel,
  output logic [7:0]        hdr_len
);

  localparam int CNT_W = $clog2(PAYLOAD_MAX + 1);

  dmac_cfg_t         cfg;
  logic              eot_clr, pay_clr, pay_inc, beat_clr, beat_inc;
  logic [CNT_W-1:0]  pay_cnt;
  logic [BEAT_W-1:0] beat_cnt;

  assign cfg_rdata = cfg;

  dmac_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr),
    .wdata   (cfg_wdata),
    .eot_clr (eot_clr),
    .cfg     (cfg)
  );

  dmac_cnt #(.W(CNT_W)) u_pay_cnt (
    .clk (clk),
    .rst (rst),
    .clr (pay_clr),
    .inc (pay_inc),
    .cnt (pay_cnt)
  );

  dmac_cnt #(.W(BEAT_W)) u_beat_cnt (
    .clk (clk),
    .rst (rst),
    .clr (beat_clr),
    .inc (beat_inc),
    .cnt (beat_cnt)
  );

  dmac_seq #(
    .PAYLOAD_MAX (PAYLOAD_MAX),
    .CNT_W       (CNT_W),
    .ADDR_W      (ADDR_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cfg_en     (cfg.en),
    .cfg_dir    (cfg.dir),
    .cfg_reload (cfg.reload),
    .cfg_burst  (cfg.burst),
    .buf_full   (buf_full),
    .buf_empty  (buf_empty),
    .dmack_n    (dmack_n),
    .eot_n      (eot_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .pay_cnt    (pay_cnt),
    .beat_cnt   (beat_cnt),
    .pay_clr    (pay_clr),
    .pay_inc    (pay_inc),
    .beat_clr   (beat_clr),
    .beat_inc   (beat_inc),
    .eot_clr    (eot_clr),
    .dma_req    (dma_req),
    .buf_rd_stb (buf_rd_stb),
    .buf_wr_stb (buf_wr_stb),
    .buf_addr   (buf_addr),
    .buf_wr_sel (buf_wr_sel),
    .hdr_len    (hdr_len)
  );

endmodule

// File: rtl/dmac_burst_ctrl_chk.sv
module dmac_burst_ctrl_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic              wdata_en,
  input logic              cfg_en,
  input logic              cfg_reload,
  input logic [1:0]        cfg_burst,
  input logic              dmack_n,
  input logic              eot_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              dma_req,
  input logic              buf_rd_stb,
  input logic              buf_wr_stb,
  input logic [ADDR_W-1:0] buf_addr,
  input logic [1:0]        buf_wr_sel
);

  // R2
  req_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_req) |-> $past(cfg_en));

  // R4
  single_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_req && !dmack_n && cfg_burst == 2'd0) |=> !dma_req);

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(buf_rd_stb && buf_wr_stb));

  // R6
  wr_payload_qual_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_wr_stb && buf_wr_sel == 2'd0) |-> $past(!dmack_n && !wr_n));

  // R6
  rd_payload_qual_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_rd_stb && buf_addr >= ADDR_W'(2)) |-> $past(!dmack_n && !rd_n));

  // R7
  eot_clears_en_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_req && !eot_n && !dmack_n && (!rd_n || !wr_n) && cfg_en &&
     !cfg_reload && !cfg_wr) |=> !cfg_en);

  // R8
  sw_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !wdata_en) |=> ##1 !dma_req);

  // R10
  hdr_order_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_wr_stb && buf_wr_sel == 2'd1) |=>
      (buf_wr_stb && buf_wr_sel == 2'd2 && buf_addr == ADDR_W'(1)));

endmodule

bind dmac_burst_ctrl dmac_burst_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_wr     (cfg_wr),
  .wdata_en   (cfg_wdata[2]),
  .cfg_en     (cfg_rdata[2]),
  .cfg_reload (cfg_rdata[4]),
  .cfg_burst  (cfg_rdata[1:0]),
  .dmack_n    (dmack_n),
  .eot_n      (eot_n),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .dma_req    (dma_req),
  .buf_rd_stb (buf_rd_stb),
  .buf_wr_stb (buf_wr_stb),
  .buf_addr   (buf_addr),
  .buf_wr_sel (buf_wr_sel)
);

// File: tb/dmac_burst_ctrl_tb.sv
module dmac_burst_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PMAX       = 40;
  localparam int AW         = $clog2(PMAX + 2);

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_wr;
  logic [7:0]    cfg_wdata;
  logic [7:0]    cfg_rdata;
  logic          buf_full, buf_empty;
  logic          dmack_n, eot_n, rd_n, wr_n;
  logic          dma_req, buf_rd_stb, buf_wr_stb;
  logic [AW-1:0] buf_addr;
  logic [1:0]    buf_wr_sel;
  logic [7:0]    hdr_len;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dmac_burst_ctrl #(.PAYLOAD_MAX(PMAX)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .buf_full(buf_full), .buf_empty(buf_empty),
    .dmack_n(dmack_n), .eot_n(eot_n), .rd_n(rd_n), .wr_n(wr_n),
    .dma_req(dma_req), .buf_rd_stb(buf_rd_stb), .buf_wr_stb(buf_wr_stb),
    .buf_addr(buf_addr), .buf_wr_sel(buf_wr_sel), .hdr_len(hdr_len)
  );

  task automatic chk(input string r, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  function automatic logic [7:0] cfgv(input logic rl, input logic dr,
                                      input logic en, input logic [1:0] bu);
    return {3'b010, rl, dr, en, bu};
  endfunction

  // one clock: drive handshake, pass the edge, sample at the falling edge
  task automatic cyc(input logic ack, input logic rdl, input logic wrl, input logic eot);
    dmack_n = ~ack; rd_n = ~rdl; wr_n = ~wrl; eot_n = ~eot;
    @(posedge clk); @(negedge clk);
    dmack_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; eot_n = 1'b1;
  endtask

  task automatic set_cfg(input logic [7:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(posedge clk); @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic start_pkt(input logic dir);
    cyc(0, 0, 0, 0);
    if (!dir) begin
      chk("R3", "skip0 rd_stb", buf_rd_stb, 1);
      chk("R3", "skip0 addr", buf_addr, 0);
      chk("R3", "skip0 req", dma_req, 0);
      cyc(0, 0, 0, 0);
      chk("R3", "skip1 rd_stb", buf_rd_stb, 1);
      chk("R3", "skip1 addr", buf_addr, 1);
      cyc(0, 0, 0, 0);
      chk("R3", "req after skip", dma_req, 1);
      chk("R3", "no pop after skip", buf_rd_stb, 0);
    end else begin
      chk("R2", "write req up", dma_req, 1);
    end
  endtask

  task automatic run_pkt(input int bcode, input logic dir, input int n, input logic eot_end);
    int blen;
    blen = (bcode == 0) ? 1 : (4 << (bcode - 1));
    for (int i = 0; i < n; i++) begin
      logic e;
      e = eot_end && (i == n - 1);
      cyc(1, !dir, dir, e);
      chk("R6", "payload strobe", dir ? buf_wr_stb : buf_rd_stb, 1);
      chk("R3", "payload addr", buf_addr, i + 2);
      if (dir) chk("R10", "payload sel", buf_wr_sel, 0);
      if (e) begin
        chk("R7", "req after eot", dma_req, 0);
      end else if (i + 1 == PMAX) begin
        chk("R11", "req after cap", dma_req, 0);
      end else if ((i + 1) % blen == 0) begin
        chk(bcode == 0 ? "R4" : "R5", "req drop at burst end", dma_req, 0);
        cyc(0, 0, 0, 0);
        chk(bcode == 0 ? "R4" : "R5", "req back after gap", dma_req, 1);
        chk("R5", "no strobe in gap", buf_rd_stb | buf_wr_stb, 0);
      end else begin
        chk("R5", "req held in burst", dma_req, 1);
      end
    end
  endtask

  task automatic hdr_chk(input int n);
    cyc(0, 0, 0, 0);
    chk("R10", "status wr_stb", buf_wr_stb, 1);
    chk("R10", "status addr", buf_addr, 0);
    chk("R10", "status sel", buf_wr_sel, 1);
    cyc(0, 0, 0, 0);
    chk("R10", "len wr_stb", buf_wr_stb, 1);
    chk("R10", "len addr", buf_addr, 1);
    chk("R10", "len sel", buf_wr_sel, 2);
    chk("R10", "len value", hdr_len, n);
  endtask

  initial begin
    rst = 1'b1; cfg_wr = 1'b0; cfg_wdata = '0;
    buf_full = 1'b0; buf_empty = 1'b0;
    dmack_n = 1'b1; eot_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "cfg reset", cfg_rdata, 8'h40);
    chk("R1", "req reset", dma_req, 0);
    chk("R1", "strobes reset", buf_rd_stb | buf_wr_stb, 0);

    // R2: read enabled while the buffer is not full
    buf_empty = 1'b1;
    set_cfg(cfgv(0, 0, 1, 2'd1));
    for (int k = 0; k < 3; k++) begin
      cyc(0, 0, 0, 0);
      chk("R2", "no read req when not full", dma_req, 0);
      chk("R2", "no pop when not full", buf_rd_stb, 0);
    end
    buf_full = 1'b1; buf_empty = 1'b0;
    start_pkt(0);
    // R8: software stop
    set_cfg(cfgv(0, 0, 0, 2'd1));
    chk("R8", "req still up at write edge", dma_req, 1);
    cyc(0, 0, 0, 0);
    chk("R8", "req down after stop", dma_req, 0);
    cyc(0, 0, 0, 0);
    chk("R8", "req stays down", dma_req, 0);

    // R2: write enabled while the buffer is not empty
    set_cfg(cfgv(0, 1, 1, 2'd0));
    for (int k = 0; k < 3; k++) begin
      cyc(0, 0, 0, 0);
      chk("R2", "no write req when not empty", dma_req, 0);
    end
    set_cfg(8'h40);

    // sweep every burst code in both directions
    for (int d = 0; d < 2; d++) begin
      for (int b = 0; b < 4; b++) begin
        logic dl;
        int   blen;
        dl   = d[0];
        blen = (b == 0) ? 1 : (4 << (b - 1));
        set_cfg(8'h40);
        buf_full  = !dl;
        buf_empty = dl;
        set_cfg(cfgv(0, dl, 1, b[1:0]));
        start_pkt(dl);
        if (b != 0) begin
          cyc(1, dl, !dl, 0);
          chk("R6", "wrong strobe no pop", buf_rd_stb, 0);
          chk("R6", "wrong strobe no write", buf_wr_stb, 0);
          chk("R6", "wrong strobe req held", dma_req, 1);
          cyc(0, !dl, dl, 1);
          chk("R7", "eot without ack ignored req", dma_req, 1);
          chk("R7", "eot without ack keeps start", cfg_rdata[2], 1);
          chk("R7", "eot without ack no strobe", buf_rd_stb | buf_wr_stb, 0);
        end
        run_pkt(b, dl, 2 * blen + 1, 1'b1);
        chk("R7", "start bit cleared by eot", cfg_rdata[2], 0);
        if (dl) hdr_chk(2 * blen + 1);
        cyc(0, 0, 0, 0);
        chk("R7", "idle after eot", dma_req, 0);
      end
    end

    // R9: auto-restart on a read
    set_cfg(8'h40);
    buf_full = 1'b1; buf_empty = 1'b0;
    set_cfg(cfgv(1, 0, 1, 2'd0));
    start_pkt(0);
    run_pkt(0, 0, 2, 1'b1);
    chk("R9", "start bit kept", cfg_rdata[2], 1);
    start_pkt(0);
    chk("R9", "restarted req", dma_req, 1);
    set_cfg(8'h40);
    cyc(0, 0, 0, 0);

    // R11: write up to capacity on a burst boundary
    buf_full = 1'b0; buf_empty = 1'b1;
    set_cfg(cfgv(0, 1, 1, 2'd2));
    start_pkt(1);
    run_pkt(2, 1, PMAX, 1'b0);
    chk("R11", "start bit kept at cap", cfg_rdata[2], 1);
    hdr_chk(PMAX);
    cyc(0, 0, 0, 0);
    chk("R11", "next packet req", dma_req, 1);
    set_cfg(8'h40);
    cyc(0, 0, 0, 0);
    chk("R8", "req down after final stop", dma_req, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule